// File: doc/BRIEF.md
# Dual-strobe presettable up/down counter

This block is a four-bit counter that moves up on the rising edge of one strobe input and down on the rising edge of a second strobe input. A count on either strobe takes effect only while the other strobe rests high. A master clear and a parallel load (active low, taking a four-bit jam word) override counting. A parameter picks decade counting (0 to 9) or full binary counting (0 to 15). Two active-low flags, one for reaching the top on the way up and one for reaching zero on the way down, let several stages be chained by wiring the flags of one stage straight into the strobes of the next.

All control and strobe inputs are asynchronous to the block. A free-running system clock samples them through two-flop synchronizers and finds strobe rising edges from the synchronized levels. A change on any input therefore shows on `cnt_q` at the third rising system clock edge after it. Strobe pulses must stay low and stay high for several system clocks.

Top module: `updown_strobe_counter`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, `cnt_q` becomes 0 and both flags read 1.
- R2: While the synchronized `clear` is high, `cnt_q` becomes 0. This takes priority over load and over both strobes.
- R3: While the synchronized `load_n` is low and `clear` is low, `cnt_q` follows `jam` and the strobes have no effect.
- R4: A rising edge on `up_strb` while `dn_strb` stays high adds one. The count wraps from the top value (9 in decade mode, 15 in binary mode) to 0.
- R5: A rising edge on `dn_strb` while `up_strb` stays high subtracts one. The count wraps from 0 to the top value.
- R6: A rising edge on one strobe while the other strobe is held low leaves `cnt_q` unchanged.
- R7: When rising edges of both strobes are seen in the same system clock cycle, `cnt_q` holds.
- R8: `carry_n` is 0 exactly while the synchronized `up_strb` is low and `cnt_q` equals the top value. `borrow_n` is 0 exactly while the synchronized `dn_strb` is low and `cnt_q` is 0. Both rest at 1 otherwise.
- R9: When `carry_n` drives the next stage's `up_strb` and `borrow_n` drives its `dn_strb`, the next stage moves by one each time this stage wraps in either direction.
- R10: In decade mode, a loaded value from 10 to 15 counts up modulo 16 (15 goes to 0) and counts down by plain decrement. Such a value never pulls `carry_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running system clock |
| rst_n | input | 1 | synchronous active-low system reset |
| clear | input | 1 | asynchronous master clear, active high |
| load_n | input | 1 | asynchronous parallel load, active low |
| jam | input | 4 | parallel load value |
| up_strb | input | 1 | count-up strobe, counts on rising edge |
| dn_strb | input | 1 | count-down strobe, counts on rising edge |
| cnt_q | output | 4 | registered count |
| carry_n | output | 1 | low while counting up at the top value |
| borrow_n | output | 1 | low while counting down at zero |

## Verification
The bench builds two cascaded pairs side by side, one pair with `DECADE=1` and one with `DECADE=0`, and drives every pair with the same stimulus. Decade mode brings the 9-to-0 wrap and the loaded illegal values 10 to 15 within reach. Binary mode brings the 15-to-0 wrap and the top-value borrow. Because each second stage is fed only by the first stage's flags, every wrap in either direction shows up as a step of the second stage's count.

// File: rtl/updown_cnt_pkg.sv
// Shared types for the dual-strobe counter.
// Assumes: operations are mutually exclusive per system clock cycle.
package updown_cnt_pkg;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_UP,
        OP_DOWN,
        OP_LOAD,
        OP_CLEAR
    } cnt_op_e;

    // Priority decode: clear, then load, then one-sided strobe edges.
    function automatic cnt_op_e cnt_decode(input logic clr, input logic ld_n,
                                           input logic up_rise, input logic dn_rise,
                                           input logic up_lvl, input logic dn_lvl);
        if (clr)                                  return OP_CLEAR;
        else if (!ld_n)                           return OP_LOAD;
        else if (up_rise && dn_rise)              return OP_HOLD;
        else if (up_rise && dn_lvl)               return OP_UP;
        else if (dn_rise && up_lvl)               return OP_DOWN;
        else                                      return OP_HOLD;
    endfunction

endpackage

// File: rtl/cnt_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes: each bit is independent; RST_VAL gives the idle level per bit.
module cnt_sync #(
    parameter int               W       = 4,
    parameter int               DEPTH   = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    // Shift the input through DEPTH flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/cnt_rise.sv
// Rising-edge finder on an already synchronized level.
// Assumes: the idle level is high, so reset loads the history flop with 1.
module cnt_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev;

    // Remember the level from the previous system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/cnt_core.sv
// Count register with clear, load, up and down steps.
// Assumes: op is already priority-decoded; MAXV is the top count.
module cnt_core
    import updown_cnt_pkg::*;
#(
    parameter int               WIDTH = 4,
    parameter logic [WIDTH-1:0] MAXV  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] jam,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] q_next;

    // Next count. An illegal value above MAXV steps by plain arithmetic.
    always_comb begin
        unique case (op)
            OP_CLEAR: q_next = '0;
            OP_LOAD:  q_next = jam;
            OP_UP:    q_next = (q == MAXV) ? '0 : q + WIDTH'(1);
            OP_DOWN:  q_next = (q == '0) ? MAXV : q - WIDTH'(1);
            default:  q_next = q;
        endcase
    end

    // Hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end
endmodule

// File: rtl/updown_strobe_counter.sv
// Dual-strobe presettable up/down counter, decade or binary.
// Assumes: all control inputs are asynchronous and are sampled by clk;
// strobe low and high phases each last several clk periods.
module updown_strobe_counter
    import updown_cnt_pkg::*;
#(
    parameter bit DECADE     = 1'b1,
    parameter int WIDTH      = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load_n,
    input  logic [WIDTH-1:0] jam,
    input  logic             up_strb,
    input  logic             dn_strb,
    output logic [WIDTH-1:0] cnt_q,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam logic [WIDTH-1:0] MAXV = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};
    localparam int               NCTL = 4;
    localparam logic [NCTL-1:0]  CTL_IDLE = 4'b0111; // clear, load_n, up, dn

    logic [NCTL-1:0] ctl_s;
    logic            clr_s, ld_n_s, up_s, dn_s;
    logic [1:0]      lvl, rise;
    logic            up_rise, dn_rise;
    cnt_op_e         op;

    cnt_sync #(.W(NCTL), .DEPTH(SYNC_DEPTH), .RST_VAL(CTL_IDLE)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({clear, load_n, up_strb, dn_strb}),
        .q    (ctl_s)
    );

    assign {clr_s, ld_n_s, up_s, dn_s} = ctl_s;
    assign lvl = {up_s, dn_s};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_edge
            cnt_rise u_rise (
                .clk  (clk),
                .rst_n(rst_n),
                .lvl  (lvl[g]),
                .rise (rise[g])
            );
        end
    endgenerate

    assign {up_rise, dn_rise} = rise;

    // Pick this cycle's operation by priority.
    always_comb op = cnt_decode(clr_s, ld_n_s, up_rise, dn_rise, up_s, dn_s);

    cnt_core #(.WIDTH(WIDTH), .MAXV(MAXV)) u_core (
        .clk  (clk),
        .rst_n(rst_n),
        .op   (op),
        .jam  (jam),
        .q    (cnt_q)
    );

    // Chain flags: low during the active strobe's low phase at the end value.
    always_comb begin
        carry_n  = !(!up_s && (cnt_q == MAXV));
        borrow_n = !(!dn_s && (cnt_q == '0));
    end
endmodule

// File: rtl/updown_strobe_counter_chk.sv
// Property checker for the dual-strobe counter, bound to every instance.
// Assumes: reads the synchronized controls and edge signals of the top.
module updown_strobe_counter_chk #(
    parameter bit DECADE = 1'b1,
    parameter int WIDTH  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_s,
    input logic             ld_n_s,
    input logic             up_s,
    input logic             dn_s,
    input logic             up_rise,
    input logic             dn_rise,
    input logic [WIDTH-1:0] jam,
    input logic [WIDTH-1:0] cnt_q,
    input logic             carry_n,
    input logic             borrow_n
);
    localparam logic [WIDTH-1:0] MAXV = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

    // R2
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_s |=> (cnt_q == '0));

    // R3
    load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_s && !ld_n_s) |=> (cnt_q == $past(jam)));

    // R4
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_s && ld_n_s && up_rise && !dn_rise && dn_s && cnt_q != MAXV)
        |=> (cnt_q == $past(cnt_q) + WIDTH'(1)));

    // R6
    up_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_s && ld_n_s && up_rise && !dn_s) |=> $stable(cnt_q));

    // R7
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_s && ld_n_s && up_rise && dn_rise) |=> $stable(cnt_q));

    // R8
    carry_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (!up_s && cnt_q == MAXV));

    // R8
    borrow_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n |-> (!dn_s && cnt_q == '0));
endmodule

bind updown_strobe_counter updown_strobe_counter_chk #(.DECADE(DECADE), .WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_s   (clr_s),
    .ld_n_s  (ld_n_s),
    .up_s    (up_s),
    .dn_s    (dn_s),
    .up_rise (up_rise),
    .dn_rise (dn_rise),
    .jam     (jam),
    .cnt_q   (cnt_q),
    .carry_n (carry_n),
    .borrow_n(borrow_n)
);

// File: tb/sim_updown_strobe_counter.sv
// Bench: two cascaded pairs (decade and binary) driven by one stimulus,
// compared against bench-side models after every operation.
module sim_updown_strobe_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] jam = 4'd0;
    logic       up_strb = 1'b1;
    logic       dn_strb = 1'b1;

    logic [3:0] d0_q, d1_q, b0_q, b1_q;
    logic       d0_c, d0_b, d1_c, d1_b, b0_c, b0_b, b1_c, b1_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int md0 = 0, md1 = 0, mb0 = 0, mb1 = 0;

    always #5 clk = ~clk;

    updown_strobe_counter #(.DECADE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .jam(jam),
        .up_strb(up_strb), .dn_strb(dn_strb), .cnt_q(d0_q), .carry_n(d0_c), .borrow_n(d0_b));
    updown_strobe_counter #(.DECADE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(1'b1), .jam(4'd0),
        .up_strb(d0_c), .dn_strb(d0_b), .cnt_q(d1_q), .carry_n(d1_c), .borrow_n(d1_b));
    updown_strobe_counter #(.DECADE(1'b0)) b0 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .jam(jam),
        .up_strb(up_strb), .dn_strb(dn_strb), .cnt_q(b0_q), .carry_n(b0_c), .borrow_n(b0_b));
    updown_strobe_counter #(.DECADE(1'b0)) b1 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(1'b1), .jam(4'd0),
        .up_strb(b0_c), .dn_strb(b0_b), .cnt_q(b1_q), .carry_n(b1_c), .borrow_n(b1_b));

    function automatic int step_up(input int v, input int top);
        return (v == top) ? 0 : ((v + 1) & 15);
    endfunction

    function automatic int step_dn(input int v, input int top);
        return (v == 0) ? top : v - 1;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_counts(input string req);
        chk(d0_q == md0[3:0], req, d0_q, md0);
        chk(b0_q == mb0[3:0], req, b0_q, mb0);
        chk(d1_q == md1[3:0], {req, " R9 decade stage 2"}, d1_q, md1);
        chk(b1_q == mb1[3:0], {req, " R9 binary stage 2"}, b1_q, mb1);
    endtask

    task automatic up_pulse();
        up_strb = 1'b0;
        tick(6);
        chk(d0_c == !(md0 == 9), "R8 decade carry_n", d0_c, !(md0 == 9));
        chk(b0_c == !(mb0 == 15), "R8 binary carry_n", b0_c, !(mb0 == 15));
        chk(d0_b == 1'b1, "R8 borrow_n idle", d0_b, 1);
        up_strb = 1'b1;
        tick(6);
        if (md0 == 9) md1 = step_up(md1, 9);
        if (mb0 == 15) mb1 = step_up(mb1, 15);
        md0 = step_up(md0, 9);
        mb0 = step_up(mb0, 15);
        check_counts("R4 R10 up step");
    endtask

    task automatic dn_pulse();
        dn_strb = 1'b0;
        tick(6);
        chk(d0_b == !(md0 == 0), "R8 decade borrow_n", d0_b, !(md0 == 0));
        chk(b0_b == !(mb0 == 0), "R8 binary borrow_n", b0_b, !(mb0 == 0));
        chk(b0_c == 1'b1, "R8 carry_n idle", b0_c, 1);
        dn_strb = 1'b1;
        tick(6);
        if (md0 == 0) md1 = step_dn(md1, 9);
        if (mb0 == 0) mb1 = step_dn(mb1, 15);
        md0 = step_dn(md0, 9);
        mb0 = step_dn(mb0, 15);
        check_counts("R5 R10 down step");
    endtask

    task automatic load_val(input int v);
        jam = v[3:0];
        load_n = 1'b0;
        tick(6);
        md0 = v;
        mb0 = v;
        check_counts("R3 load");
        load_n = 1'b1;
        tick(4);
    endtask

    task automatic clear_pulse(input bit with_load);
        clear = 1'b1;
        if (with_load) begin
            jam = 4'd7;
            load_n = 1'b0;
        end
        tick(6);
        md0 = 0; md1 = 0; mb0 = 0; mb1 = 0;
        check_counts("R2 clear");
        clear = 1'b0;
        load_n = 1'b1;
        tick(4);
    endtask

    // One strobe rises while the other is held low: no step (R6).
    task automatic blocked_up();
        load_val(5);
        dn_strb = 1'b0;
        tick(6);
        up_strb = 1'b0;
        tick(6);
        up_strb = 1'b1;
        tick(6);
        check_counts("R6 up ignored while down low");
        dn_strb = 1'b1;
        tick(6);
        md0 = 4; mb0 = 4;
        check_counts("R5 down after blocked up");
    endtask

    // Both strobes rise together: hold (R7).
    task automatic both_pulse();
        load_val(4);
        up_strb = 1'b0;
        dn_strb = 1'b0;
        tick(6);
        up_strb = 1'b1;
        dn_strb = 1'b1;
        tick(6);
        check_counts("R7 both edges hold");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        tick(4);
        chk(d0_q == 4'd0, "R1 reset count", d0_q, 0);
        chk(b0_q == 4'd0, "R1 reset count", b0_q, 0);
        chk(d0_c && d0_b && b0_c && b0_b, "R1 reset flags", {d0_c, d0_b, b0_c, b0_b}, 15);
        rst_n = 1'b1;
        tick(4);
        check_counts("R1 after reset");

        // Directed: wraps in both directions and both modes.
        for (int i = 0; i < 17; i++) up_pulse();
        for (int i = 0; i < 3; i++) dn_pulse();
        clear_pulse(1'b0);
        for (int i = 0; i < 2; i++) dn_pulse();
        // Directed: illegal decade values (R10).
        load_val(12);
        for (int i = 0; i < 5; i++) up_pulse();
        load_val(11);
        dn_pulse();
        // Directed: clear beats load (R2), blocked and simultaneous edges.
        clear_pulse(1'b1);
        blocked_up();
        both_pulse();

        // Random mix.
        for (int i = 0; i < 300; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r < 7)       up_pulse();
            else if (r < 12) dn_pulse();
            else if (r < 14) load_val(int'($urandom % 16));
            else if (r == 14) clear_pulse(1'b0);
            else if (($urandom % 2) == 0) blocked_up();
            else both_pulse();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule